// File: doc/BRIEF.md
# Static Memory Write-Cycle Sequencer

This block produces the control waveform for one write cycle to an external static memory on one chip select. It drives an active-low chip select, an active-low write strobe, the address and write-data buses, and an enable that tells the pads to drive the data bus. All timings are whole clock cycles. The setup and pulse of the write strobe and of the chip select can each be set, along with a total cycle length that both signals share. Hold times are never set directly. Each hold is whatever remains of the total cycle after that signal's setup and pulse, so the two strobes always end on the same cycle boundary.

A client offers a write with `req_valid`, `req_addr` and `req_data`. The write is taken on a clock edge where `req_rdy` is high. `wr_ack` pulses in the last clock of the cycle. A request offered while `wr_ack` is high starts on the very next clock. A strobe that has zero setup and zero hold therefore stays asserted across the boundary between the two writes. The mode input `cfg_we_mode` picks the signal that opens the data-drive window: 1 selects the write strobe and 0 selects the chip select.

The controller has two states. `ST_IDLE` waits for a request. `ST_BUSY` runs a cycle counter. The transitions are:
- ST_IDLE to ST_BUSY when a request is taken.
- ST_BUSY to ST_BUSY while the counter advances.
- ST_BUSY to ST_BUSY with the counter reset to 0 when a chained request is taken on the final count.
- ST_BUSY to ST_IDLE on the final count with no request taken.

Top module: `sram_wr_sequencer`

## Requirements
- R1: After reset, `mem_cs_n`=1, `mem_we_n`=1, `mem_doe`=0, `wr_ack`=0, `req_rdy`=1, `err_pulse`=0 and `err_len`=0. Whenever no cycle is running, both strobes are 1 and `mem_doe` is 0.
- R2: `req_addr` and `req_data` are captured on the accepting edge. They appear on `mem_addr` and `mem_dout` from count 0 and stay unchanged for the whole cycle.
- R3: Count 0 is the first clock after the accepting edge. `mem_we_n` is 0 exactly while `we_setup ≤ count < we_setup + we_pulse`.
- R4: `mem_cs_n` is 0 exactly while `cs_setup ≤ count < cs_setup + cs_pulse`.
- R5: A cycle lasts `cfg_cycle` clocks. `wr_ack` is 1 only at the final count, `cfg_cycle − 1`, so each hold is the total minus that signal's setup and pulse.
- R6: With `cfg_we_mode`=1, `mem_doe` is 1 from count `we_setup` to the end of the cycle, whatever the chip-select timing is.
- R7: With `cfg_we_mode`=0, `mem_doe` is 1 from count `cs_setup` to the end of the cycle.
- R8: A request offered while either pulse field is 0 is refused. No strobe moves and no `wr_ack` follows. `err_pulse` becomes 1 and stays 1 until reset.
- R9: If setup + pulse of either strobe exceeds `cfg_cycle`, that hold becomes zero. The cycle then lasts max(`cfg_cycle`, we setup+pulse, cs setup+pulse) clocks. `err_len` becomes 1 and stays 1 until reset.
- R10: A request taken in the `wr_ack` clock starts at count 0 on the next clock. With zero setup and zero hold, a strobe stays 0 without a gap across the two cycles.
- R11: `req_rdy` is 1 only when idle or at the final count. A request offered at any other time has no effect on the running cycle or on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we_setup | input | TW | Write-strobe setup, in clocks |
| cfg_we_pulse | input | TW | Write-strobe pulse, in clocks (must be ≥1) |
| cfg_cs_setup | input | TW | Chip-select setup, in clocks |
| cfg_cs_pulse | input | TW | Chip-select pulse, in clocks (must be ≥1) |
| cfg_cycle | input | TW | Total write-cycle length, in clocks |
| cfg_we_mode | input | 1 | 1: write strobe opens the data window; 0: chip select opens it |
| req_valid | input | 1 | Write request offered |
| req_addr | input | AW | Request address |
| req_data | input | DW | Request write data |
| req_rdy | output | 1 | Request can be taken on this edge |
| wr_ack | output | 1 | Final clock of the write cycle |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Memory write data |
| mem_doe | output | 1 | Data-bus drive enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| err_pulse | output | 1 | Sticky flag: a request was refused for a zero pulse |
| err_len | output | 1 | Sticky flag: setup + pulse exceeded the cycle length |

## Verification
The bench sweeps both modes across every combination of the small timing settings. For each write it predicts, clock by clock, every strobe, the drive enable, the acknowledge and the ready signal. The strobes, the drive enable and `wr_ack` are decoded directly from the counter and the latched timing. A counter or latched field that goes wrong therefore shows as a misplaced edge in the same clock. A wrong cycle length moves `wr_ack` and `req_rdy` by at least one clock within that cycle. A fault in state or capture shows in the clock after it happens: a lost chained request gives a high strobe at the next count 0, and an address that changes mid-cycle differs from the value that was offered.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } seq_state_t;
endpackage

// File: rtl/sram_wr_limits.sv
// Derives the effective cycle length and configuration faults from the live timing inputs.
module sram_wr_limits #(
    parameter int TW = 4
) (
    input  logic [TW-1:0] we_setup,
    input  logic [TW-1:0] we_pulse,
    input  logic [TW-1:0] cs_setup,
    input  logic [TW-1:0] cs_pulse,
    input  logic [TW-1:0] cycle,
    output logic [TW:0]   last_cnt,
    output logic          pulse_bad,
    output logic          len_over
);
    logic [TW:0] we_end, cs_end, cyc_ext, len;

    always_comb begin
        we_end  = {1'b0, we_setup} + {1'b0, we_pulse};
        cs_end  = {1'b0, cs_setup} + {1'b0, cs_pulse};
        cyc_ext = {1'b0, cycle};
        len     = cyc_ext;
        if (we_end > len) len = we_end;
        if (cs_end > len) len = cs_end;
        last_cnt  = len - {{TW{1'b0}}, 1'b1};
        pulse_bad = (we_pulse == '0) || (cs_pulse == '0);
        len_over  = (we_end > cyc_ext) || (cs_end > cyc_ext);
    end
endmodule

// File: rtl/sram_wr_window.sv
// Decodes one strobe window and its "setup elapsed" flag from the cycle counter.
module sram_wr_window #(
    parameter int TW = 4
) (
    input  logic          active,
    input  logic [TW:0]   cnt,
    input  logic [TW-1:0] setup,
    input  logic [TW-1:0] pulse,
    output logic          on,
    output logic          past_setup
);
    logic [TW:0] stop;

    always_comb begin
        stop       = {1'b0, setup} + {1'b0, pulse};
        past_setup = active && (cnt >= {1'b0, setup});
        on         = past_setup && (cnt < stop);
    end
endmodule

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer
    import sram_wr_pkg::*;
#(
    parameter int TW = 4,
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cfg_we_setup,
    input  logic [TW-1:0] cfg_we_pulse,
    input  logic [TW-1:0] cfg_cs_setup,
    input  logic [TW-1:0] cfg_cs_pulse,
    input  logic [TW-1:0] cfg_cycle,
    input  logic          cfg_we_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_rdy,
    output logic          wr_ack,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    output logic          mem_doe,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          err_pulse,
    output logic          err_len
);
    localparam int NSTROBE = 2;  // index 0: write strobe, index 1: chip select
    localparam int CW      = TW + 1;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] last_q, last_live;
    logic [TW-1:0] setup_q [NSTROBE];
    logic [TW-1:0] pulse_q [NSTROBE];
    logic          mode_q;
    logic          pulse_bad, len_over;
    logic          busy, at_last, take_ok, take_bad;
    logic [NSTROBE-1:0] win_on, win_past;

    sram_wr_limits #(.TW(TW)) u_limits (
        .we_setup (cfg_we_setup),
        .we_pulse (cfg_we_pulse),
        .cs_setup (cfg_cs_setup),
        .cs_pulse (cfg_cs_pulse),
        .cycle    (cfg_cycle),
        .last_cnt (last_live),
        .pulse_bad(pulse_bad),
        .len_over (len_over)
    );

    for (genvar g = 0; g < NSTROBE; g++) begin : g_win
        sram_wr_window #(.TW(TW)) u_win (
            .active    (busy),
            .cnt       (cnt_q),
            .setup     (setup_q[g]),
            .pulse     (pulse_q[g]),
            .on        (win_on[g]),
            .past_setup(win_past[g])
        );
    end

    assign busy     = (state_q == ST_BUSY);
    assign at_last  = busy && (cnt_q == last_q);
    assign req_rdy  = !busy || at_last;
    assign take_ok  = req_valid && req_rdy && !pulse_bad;
    assign take_bad = req_valid && req_rdy && pulse_bad;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_ok) begin
                    state_d = ST_BUSY;
                    cnt_d   = '0;
                end
            end
            ST_BUSY: begin
                if (at_last) begin
                    cnt_d   = '0;
                    state_d = take_ok ? ST_BUSY : ST_IDLE;
                end else begin
                    cnt_d = cnt_q + {{TW{1'b0}}, 1'b1};
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // capture of request and timing, sticky faults
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= '0;
            mode_q     <= 1'b0;
            mem_addr   <= '0;
            mem_dout   <= '0;
            err_pulse  <= 1'b0;
            err_len    <= 1'b0;
            setup_q[0] <= '0;
            setup_q[1] <= '0;
            pulse_q[0] <= '0;
            pulse_q[1] <= '0;
        end else begin
            if (take_bad) err_pulse <= 1'b1;
            if (take_ok) begin
                if (len_over) err_len <= 1'b1;
                last_q     <= last_live;
                mode_q     <= cfg_we_mode;
                mem_addr   <= req_addr;
                mem_dout   <= req_data;
                setup_q[0] <= cfg_we_setup;
                pulse_q[0] <= cfg_we_pulse;
                setup_q[1] <= cfg_cs_setup;
                pulse_q[1] <= cfg_cs_pulse;
            end
        end
    end

    // outputs
    always_comb begin
        wr_ack   = at_last;
        mem_we_n = !win_on[0];
        mem_cs_n = !win_on[1];
        mem_doe  = mode_q ? win_past[0] : win_past[1];
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_we_n && mem_cs_n && !mem_doe));
    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |-> ($stable(mem_addr) && $stable(mem_dout)));
    assert_doe_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q && !mem_we_n) |-> mem_doe);
    assert_doe_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_q && !mem_cs_n) |-> mem_doe);
    assert_sticky_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_pulse);
    assert_sticky_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |=> err_len);
    assert_chain_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && req_valid && !pulse_bad) |=> (busy && cnt_q == '0));
    assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && pulse_bad) |=> !busy);
endmodule

// File: tb/sram_wr_sequencer_test.sv
`timescale 1ns/1ps
module sram_wr_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] we_s = 0, we_p = 1, cs_s = 0, cs_p = 1, cyc = 1;
    logic       mode = 1'b1, valid = 1'b0;
    logic [7:0] addr = 0, data = 0;
    logic       rdy, ack, doe, cs_n, we_n, e_p, e_l;
    logic [7:0] m_addr, m_dout;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_wr_sequencer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_setup(we_s), .cfg_we_pulse(we_p),
        .cfg_cs_setup(cs_s), .cfg_cs_pulse(cs_p),
        .cfg_cycle(cyc), .cfg_we_mode(mode),
        .req_valid(valid), .req_addr(addr), .req_data(data),
        .req_rdy(rdy), .wr_ack(ack), .mem_addr(m_addr), .mem_dout(m_dout),
        .mem_doe(doe), .mem_cs_n(cs_n), .mem_we_n(we_n),
        .err_pulse(e_p), .err_len(e_l)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle_check(input string tag);
        check({tag, " we_n idle"}, we_n, 1);
        check({tag, " cs_n idle"}, cs_n, 1);
        check({tag, " doe idle"}, doe, 0);
        check({tag, " ack idle"}, ack, 0);
    endtask

    // one write from idle, checked clock by clock; called at a negedge
    task automatic run_write(input int ws, input int wp, input int cs, input int cp,
                             input int cy, input bit md, input int a, input int d);
        int len;
        bit clamp;
        len = cy;
        if (ws + wp > len) len = ws + wp;
        if (cs + cp > len) len = cs + cp;
        clamp = (len != cy);
        we_s = 4'(ws); we_p = 4'(wp); cs_s = 4'(cs); cs_p = 4'(cp);
        cyc = 4'(cy); mode = md; addr = 8'(a); data = 8'(d); valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        for (int c = 0; c < len; c++) begin
            check("R3 we_n", we_n, (c >= ws && c < ws + wp) ? 0 : 1);
            check("R4 cs_n", cs_n, (c >= cs && c < cs + cp) ? 0 : 1);
            if (md) check("R6 doe", doe, (c >= ws) ? 1 : 0);
            else    check("R7 doe", doe, (c >= cs) ? 1 : 0);
            if (clamp) check("R9 ack", ack, (c == len - 1) ? 1 : 0);
            else       check("R5 ack", ack, (c == len - 1) ? 1 : 0);
            check("R11 rdy", rdy, (c == len - 1) ? 1 : 0);
            check("R2 addr", m_addr, a & 8'hFF);
            check("R2 data", m_dout, d & 8'hFF);
            @(negedge clk);
        end
        idle_check("R1 after");
        check("R11 rdy after", rdy, 1);
    endtask

    initial begin : watchdog
        int n = 0;
        while (!finished) begin
            @(posedge clk);
            n++;
            if (n > 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        #1;
        check("R1 we_n reset", we_n, 1);
        check("R1 cs_n reset", cs_n, 1);
        check("R1 doe reset", doe, 0);
        check("R1 ack reset", ack, 0);
        check("R1 rdy reset", rdy, 1);
        check("R1 err_pulse reset", e_p, 0);
        check("R1 err_len reset", e_l, 0);
        do_reset();

        // R8: zero write pulse is refused
        we_s = 1; we_p = 0; cs_s = 0; cs_p = 2; cyc = 3; addr = 8'h5A; valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            idle_check("R8 refused");
            @(negedge clk);
        end
        check("R8 err_pulse", e_p, 1);
        check("R8 addr untouched", m_addr, 0);
        // zero chip-select pulse also refused; flag stays
        we_p = 1; cs_p = 0; valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        idle_check("R8 refused cs");
        check("R8 err_pulse sticky", e_p, 1);
        check("R9 no len error", e_l, 0);

        // R9: clamp raises err_len
        do_reset();
        run_write(2, 3, 0, 1, 3, 1'b1, 8'h11, 8'h22);
        check("R9 err_len", e_l, 1);
        run_write(0, 1, 0, 1, 2, 1'b0, 8'h12, 8'h23);
        check("R9 err_len sticky", e_l, 1);

        // R11: request mid-cycle ignored
        do_reset();
        we_s = 1; we_p = 1; cs_s = 0; cs_p = 3; cyc = 4; mode = 1'b1;
        addr = 8'hA1; data = 8'hB1; valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        @(negedge clk);
        addr = 8'hC3; data = 8'hD3; valid = 1'b1;   // count 1, not ready
        check("R11 rdy mid", rdy, 0);
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        check("R11 addr kept", m_addr, 8'hA1);
        check("R11 data kept", m_dout, 8'hB1);
        @(negedge clk);
        check("R11 ack at end", ack, 1);
        @(negedge clk);
        idle_check("R11 no restart");

        // R10: back-to-back with zero setup and hold
        we_s = 0; we_p = 3; cs_s = 0; cs_p = 3; cyc = 3; mode = 1'b1;
        addr = 8'h01; data = 8'h10; valid = 1'b1;
        @(posedge clk); @(negedge clk);
        valid = 1'b0;
        for (int c = 0; c < 6; c++) begin
            check("R10 we_n held", we_n, 0);
            check("R10 cs_n held", cs_n, 0);
            check("R10 doe held", doe, 1);
            check("R10 ack", ack, (c == 2 || c == 5) ? 1 : 0);
            check("R10 addr", m_addr, (c < 3) ? 8'h01 : 8'h02);
            if (c == 2) begin
                addr = 8'h02; data = 8'h20; valid = 1'b1;
            end
            @(negedge clk);
            if (c == 3) valid = 1'b0;
        end
        idle_check("R10 end");

        // sweep of timing and modes
        do_reset();
        for (int md = 0; md < 2; md++)
            for (int ws = 0; ws < 3; ws++)
                for (int wp = 1; wp < 3; wp++)
                    for (int cs = 0; cs < 3; cs++)
                        for (int cp = 1; cp < 3; cp++)
                            for (int cy = 1; cy < 6; cy++)
                                run_write(ws, wp, cs, cp, cy, md[0],
                                          ws * 16 + cs * 4 + cy, wp * 64 + cp * 8 + md);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule